// File: doc/BRIEF.md
# Maskable Interrupt Aggregator with Sticky or Line-Following Pending Bits

This block collects up to 32 external interrupt request lines and merges them into a single interrupt request for a processor core. Each line passes through a synchronizer, and a rising edge on a line is a new request. A new request marks a pending bit in a status register and sends a one-cycle wake pulse to the power manager, so that it leaves its doze and sleep states. The core interrupt is raised while the core's global interrupt enable is high and some pending bit has its mask bit set. Lines 0 and 1 ignore the mask.

Software reaches four registers through a simple synchronous port with registered read data. The registers are a mask, a priority word that is stored but not decoded, the status word, and a read-only flag that reports whether the controller is enabled. A strap input selects how pending bits behave. They either stay set until software acknowledges them by writing ones, or they follow their line and clear when it drops. A second strap disables the controller. In that mode the status word is left alone, and any synchronized request high drives the core interrupt, gated only by the global enable.

Top module: `irq_gather`

## Requirements
- R1: Reset (synchronous, active high) clears the mask, priority and status registers, and drives the core interrupt and wake outputs low.
- R2: Only a low-to-high transition of a line counts as a new request. A line held high creates no further pending bit after it is acknowledged, and no further wake pulse.
- R3: With the controller enabled, a new request sets its status bit whether or not the line is masked. The bit can be read at address 2 once the third rising clock edge after the line goes high has passed.
- R4: With the controller enabled, the core interrupt is high in the cycle after the global enable is high and some status bit has its mask bit set. Lines 0 and 1 count as always unmasked. For a new request the interrupt therefore appears after the fourth rising edge.
- R5: When the global enable rises while an unmasked status bit is pending, the core interrupt is raised after the next rising edge.
- R6: When the sticky strap is 1, status bits stay set after their line drops. When it is 0, a status bit clears as soon as its synchronized line is low.
- R7: With the controller disabled, lines do not change the status register. The core interrupt equals the global enable ANDed with the OR of the synchronized lines, one register later.
- R8: Every new request, in either enable state, produces a one-cycle wake pulse after the third rising edge from the line going high.
- R9: Reading address 3 returns the enable strap in bit 0 and zeros in the other bits.
- R10: Writes to address 0 (mask) and address 1 (priority) store the data as written, and reads return it. Writing to address 2 clears every status bit written as 1. A new request in the same cycle wins over the clear.
- R11: The core interrupt falls in the cycle after the last unmasked status bit clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines_i | input | N_LINES | Asynchronous interrupt request lines |
| gie_i | input | 1 | Core global interrupt enable |
| cfg_enable_i | input | 1 | 1: controller active, 0: bypass |
| cfg_sticky_i | input | 1 | 1: sticky pending bits, 0: line-following |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1: write, 0: read |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read strobe |
| core_irq_o | output | 1 | Interrupt request to the core |
| wake_o | output | 1 | One-cycle wake request to the power manager |

## Verification
A corrupted status bit shows up at the core interrupt one cycle later when its line is unmasked. It shows up on a read of address 2 in every case, so the bench reads the status word after each random stimulus step as well as watching the interrupt. A broken edge detector shows up as a wake pulse that is missing or repeated in the cycle after the third edge, or as a pending bit that comes back after a line held high is acknowledged. Mode errors appear within one cycle of the mode change, as status bits that do not follow their lines or that are not frozen.

// File: rtl/irqg_pkg.sv
package irqg_pkg;

    localparam int unsigned DATA_W      = 32;
    localparam int unsigned ADDR_W      = 2;
    localparam int unsigned FIXED_LINES = 2;   // lines that ignore the mask

    typedef enum logic [ADDR_W-1:0] {
        RA_MASK = 2'd0,
        RA_PRIO = 2'd1,
        RA_STAT = 2'd2,
        RA_PRES = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic              sel;
        logic              we;
        reg_addr_e         addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic irq;
        logic wake;
    } core_out_t;

    // Mask as seen by the interrupt decision: the lowest lines always pass.
    function automatic logic [DATA_W-1:0] eff_mask(input logic [DATA_W-1:0] m);
        logic [DATA_W-1:0] fixed;
        fixed = '0;
        for (int i = 0; i < int'(FIXED_LINES); i++) fixed[i] = 1'b1;
        return m | fixed;
    endfunction

    function automatic logic is_write(input bus_req_t r, input reg_addr_e a);
        return r.sel && r.we && (r.addr == a);
    endfunction

endpackage

// File: rtl/irqg_sync.sv
module irqg_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lines_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] prev_q;

    for (genvar g = 0; g < int'(STAGES); g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '0;
                else     stage_q[g] <= lines_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '0;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= stage_q[STAGES-1];
    end

    assign sync_o = stage_q[STAGES-1];
    assign rise_o = stage_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/irqg_status.sv
module irqg_status
    import irqg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable_i,
    input  logic              sticky_i,
    input  bus_req_t          req_i,
    input  logic [DATA_W-1:0] sync_i,
    input  logic [DATA_W-1:0] rise_i,
    output logic [DATA_W-1:0] status_o
);
    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] status_nxt;
    logic [DATA_W-1:0] ack;

    assign ack = is_write(req_i, RA_STAT) ? req_i.wdata : '0;

    always_comb begin
        status_nxt = status_q & ~ack;
        if (enable_i) begin
            if (!sticky_i) status_nxt = status_nxt & sync_i;
            status_nxt = status_nxt | rise_i;   // a new request beats the ack
        end
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= status_nxt;
    end

    assign status_o = status_q;
endmodule

// File: rtl/irqg_regfile.sv
module irqg_regfile
    import irqg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req_i,
    input  logic              enable_i,
    input  logic [DATA_W-1:0] status_i,
    output logic [DATA_W-1:0] mask_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] prio_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_mux;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            prio_q <= '0;
        end else begin
            if (is_write(req_i, RA_MASK)) mask_q <= req_i.wdata;
            if (is_write(req_i, RA_PRIO)) prio_q <= req_i.wdata;
        end
    end

    always_comb begin
        unique case (req_i.addr)
            RA_MASK: rd_mux = mask_q;
            RA_PRIO: rd_mux = prio_q;
            RA_STAT: rd_mux = status_i;
            RA_PRES: rd_mux = {{(DATA_W-1){1'b0}}, enable_i};
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                          rdata_q <= '0;
        else if (req_i.sel && !req_i.we)  rdata_q <= rd_mux;
    end

    assign mask_o  = mask_q;
    assign rdata_o = rdata_q;
endmodule

// File: rtl/irqg_core_out.sv
module irqg_core_out
    import irqg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable_i,
    input  logic              gie_i,
    input  logic [DATA_W-1:0] status_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic [DATA_W-1:0] sync_i,
    input  logic [DATA_W-1:0] rise_i,
    output core_out_t         out_o
);
    core_out_t out_q;
    core_out_t out_nxt;

    always_comb begin
        out_nxt.wake = |rise_i;
        if (enable_i) out_nxt.irq = gie_i && (|(status_i & eff_mask(mask_i)));
        else          out_nxt.irq = gie_i && (|sync_i);
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_nxt;
    end

    assign out_o = out_q;
endmodule

// File: rtl/irq_gather.sv
module irq_gather
    import irqg_pkg::*;
#(
    parameter int unsigned N_LINES     = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] irq_lines_i,
    input  logic               gie_i,
    input  logic               cfg_enable_i,
    input  logic               cfg_sticky_i,
    input  logic               bus_sel_i,
    input  logic               bus_we_i,
    input  logic [1:0]         bus_addr_i,
    input  logic [31:0]        bus_wdata_i,
    output logic [31:0]        bus_rdata_o,
    output logic               core_irq_o,
    output logic               wake_o
);
    bus_req_t          req;
    logic [DATA_W-1:0] lines_w;
    logic [DATA_W-1:0] sync_w;
    logic [DATA_W-1:0] rise_w;
    logic [DATA_W-1:0] status_w;
    logic [DATA_W-1:0] mask_w;
    core_out_t         out_w;

    assign req.sel   = bus_sel_i;
    assign req.we    = bus_we_i;
    assign req.addr  = reg_addr_e'(bus_addr_i);
    assign req.wdata = bus_wdata_i;

    if (N_LINES < DATA_W) begin : g_pad
        assign lines_w = {{(DATA_W-N_LINES){1'b0}}, irq_lines_i};
    end else begin : g_full
        assign lines_w = irq_lines_i;
    end

    irqg_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .lines_i(lines_w), .sync_o(sync_w), .rise_o(rise_w)
    );

    irqg_status u_status (
        .clk(clk), .rst(rst), .enable_i(cfg_enable_i), .sticky_i(cfg_sticky_i),
        .req_i(req), .sync_i(sync_w), .rise_i(rise_w), .status_o(status_w)
    );

    irqg_regfile u_regs (
        .clk(clk), .rst(rst), .req_i(req), .enable_i(cfg_enable_i),
        .status_i(status_w), .mask_o(mask_w), .rdata_o(bus_rdata_o)
    );

    irqg_core_out u_out (
        .clk(clk), .rst(rst), .enable_i(cfg_enable_i), .gie_i(gie_i),
        .status_i(status_w), .mask_i(mask_w), .sync_i(sync_w), .rise_i(rise_w),
        .out_o(out_w)
    );

    assign core_irq_o = out_w.irq;
    assign wake_o     = out_w.wake;
endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk
    import irqg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              gie_i,
    input logic              cfg_enable_i,
    input logic              cfg_sticky_i,
    input logic              bus_sel_i,
    input logic              bus_we_i,
    input logic [1:0]        bus_addr_i,
    input logic [DATA_W-1:0] sync_w,
    input logic [DATA_W-1:0] rise_w,
    input logic [DATA_W-1:0] status_w,
    input logic [DATA_W-1:0] mask_w,
    input logic              core_irq_o,
    input logic              wake_o
);
    logic ack_wr;
    assign ack_wr = bus_sel_i && bus_we_i && (bus_addr_i == 2'd2);

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (status_w == '0 && mask_w == '0 && !core_irq_o && !wake_o)); // R1

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
        (cfg_enable_i && rise_w != '0) |=> ((status_w & $past(rise_w)) == $past(rise_w))); // R3

    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (cfg_enable_i && !cfg_sticky_i) |=> ((status_w & ~$past(sync_w)) == '0)); // R6

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (cfg_enable_i && cfg_sticky_i && !ack_wr) |=> ((status_w & $past(status_w)) == $past(status_w))); // R6

    AST_BYPASS_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!cfg_enable_i && !ack_wr) |=> $stable(status_w)); // R7

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
        (cfg_enable_i && gie_i && ((status_w & eff_mask(mask_w)) != '0)) |=> core_irq_o); // R4

    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
        (cfg_enable_i && ((status_w & eff_mask(mask_w)) == '0)) |=> !core_irq_o); // R11

    AST_WAKE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> ($past(rise_w) != '0)); // R8
endmodule

bind irq_gather irq_gather_chk u_chk (
    .clk(clk), .rst(rst), .gie_i(gie_i), .cfg_enable_i(cfg_enable_i),
    .cfg_sticky_i(cfg_sticky_i), .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i),
    .bus_addr_i(bus_addr_i), .sync_w(sync_w), .rise_w(rise_w),
    .status_w(status_w), .mask_w(mask_w), .core_irq_o(core_irq_o), .wake_o(wake_o)
);

// File: tb/irq_gather_tb.sv
module irq_gather_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] lines = '0;
    logic        gie = 1'b0;
    logic        en = 1'b1;
    logic        sticky = 1'b1;
    logic        sel = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        wake;

    int nchk = 0;
    int nfail = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    irq_gather u_dut (
        .clk(clk), .rst(rst), .irq_lines_i(lines), .gie_i(gie),
        .cfg_enable_i(en), .cfg_sticky_i(sticky), .bus_sel_i(sel), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .core_irq_o(irq), .wake_o(wake)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        sel = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        d = rdata;
        sel = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    // Expected status after a settled line change (from R3, R6, R7).
    function automatic logic [31:0] next_status(input logic [31:0] st, input logic [31:0] l0,
                                                input logic [31:0] l1, input logic e, input logic s);
        logic [31:0] r;
        r = st;
        if (e && !s) r = r & l0;
        if (e) r = r | (l1 & ~l0);
        if (e && !s) r = r & l1;
        return r;
    endfunction

    // Expected interrupt once settled (from R4, R7).
    function automatic logic exp_irq(input logic [31:0] st, input logic [31:0] m,
                                     input logic [31:0] l, input logic e, input logic g);
        if (e) return g && ((st & (m | 32'h3)) != 0);
        return g && (l != 0);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] st_m;
        logic [31:0] mask_m;
        logic [31:0] nl;
        logic [31:0] w;
        int unsigned seed;
        seed = 32'h1d2c_3b4a;
        void'($urandom(seed));

        cyc(3);
        rst = 1'b0;
        cyc(1);

        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 wake", {31'b0, wake}, 32'h0);
        rd(2'd0, d); chk("R1 mask", d, 32'h0);
        rd(2'd1, d); chk("R1 prio", d, 32'h0);
        rd(2'd2, d); chk("R1 status", d, 32'h0);

        // R10 plain register readback
        wr(2'd0, 32'ha5a5_0f0c); rd(2'd0, d); chk("R10 mask", d, 32'ha5a5_0f0c);
        wr(2'd1, 32'h1234_5678); rd(2'd1, d); chk("R10 prio", d, 32'h1234_5678);
        wr(2'd0, 32'h0);

        // R9 presence flag
        rd(2'd3, d); chk("R9 present en=1", d, 32'h1);
        en = 1'b0; rd(2'd3, d); chk("R9 present en=0", d, 32'h0);
        en = 1'b1;

        // R3 masked line still sets status, R4 masked line gives no irq
        gie = 1'b1; sticky = 1'b1;
        lines[5] = 1'b1; cyc(6);
        rd(2'd2, d); chk("R3 masked set", d, 32'h20);
        chk("R4 masked no irq", {31'b0, irq}, 32'h0);

        // R4 line 0 ignores mask, latency; R8 wake pulse
        lines[0] = 1'b1; cyc(3);
        chk("R8 wake after 3rd edge", {31'b0, wake}, 32'h1);
        chk("R4 irq not yet", {31'b0, irq}, 32'h0);
        cyc(1);
        chk("R4 irq after 4th edge", {31'b0, irq}, 32'h1);
        chk("R8 wake one cycle", {31'b0, wake}, 32'h0);

        // R11 irq falls the cycle after ack; R2 held-high line does not re-pend
        wr(2'd2, 32'h21);
        chk("R11 irq still high", {31'b0, irq}, 32'h1);
        cyc(1);
        chk("R11 irq dropped", {31'b0, irq}, 32'h0);
        cyc(5);
        rd(2'd2, d); chk("R2 held high no repend", d, 32'h0);
        chk("R2 no wake", {31'b0, wake}, 32'h0);

        // R6 sticky mode
        lines = '0; cyc(6);
        lines[9] = 1'b1; cyc(6);
        lines[9] = 1'b0; cyc(6);
        rd(2'd2, d); chk("R6 sticky keeps", d, 32'h200);
        wr(2'd2, 32'hffff_ffff);

        // R6 line-following mode
        sticky = 1'b0;
        lines[9] = 1'b1; cyc(6);
        rd(2'd2, d); chk("R6 level set", d, 32'h200);
        lines[9] = 1'b0; cyc(6);
        rd(2'd2, d); chk("R6 level clears", d, 32'h0);

        // R5 global enable rising with pending
        sticky = 1'b1; gie = 1'b0;
        wr(2'd0, 32'h1000);
        lines[12] = 1'b1; cyc(6);
        chk("R5 gated off", {31'b0, irq}, 32'h0);
        gie = 1'b1; cyc(1);
        chk("R5 raised after enable", {31'b0, irq}, 32'h1);
        lines = '0; cyc(3); wr(2'd2, 32'hffff_ffff); cyc(2);

        // R10 new request beats ack in the same cycle
        lines[3] = 1'b1; cyc(2);
        wr(2'd2, 32'h8);
        rd(2'd2, d); chk("R10 set beats clear", d, 32'h8);
        lines = '0; cyc(3); wr(2'd2, 32'hffff_ffff); cyc(2);

        // R7 bypass
        en = 1'b0; gie = 1'b1;
        lines[20] = 1'b1; cyc(3);
        chk("R7 bypass irq", {31'b0, irq}, 32'h1);
        chk("R8 wake in bypass", {31'b0, wake}, 32'h1);
        cyc(3);
        rd(2'd2, d); chk("R7 status frozen", d, 32'h0);
        gie = 1'b0; cyc(1);
        chk("R7 gie gates bypass", {31'b0, irq}, 32'h0);
        lines = '0; cyc(6); en = 1'b1; cyc(2);
        rd(2'd2, d); chk("R7 status after bypass", d, 32'h0);

        // Random phase: R3 R4 R6 R7 R10 against the model
        st_m = '0; mask_m = 32'h1000;
        for (int it = 0; it < 60; it++) begin
            if ($urandom % 5 == 0) begin
                mask_m = $urandom;
                wr(2'd0, mask_m);
            end
            nl = lines ^ ($urandom & $urandom & $urandom);
            en = ($urandom % 4) != 0;
            sticky = $urandom % 2;
            gie = $urandom % 2;
            st_m = next_status(st_m, lines, nl, en, sticky);
            lines = nl;
            cyc(6);
            rd(2'd2, d); chk("R3/R6/R7 random status", d, st_m);
            chk("R4/R7 random irq", {31'b0, irq}, {31'b0, exp_irq(st_m, mask_m, lines, en, gie)});
            if ($urandom % 3 == 0) begin
                w = $urandom;
                wr(2'd2, w);
                st_m = st_m & ~w;
                cyc(1);
                chk("R10/R11 random ack irq", {31'b0, irq}, {31'b0, exp_irq(st_m, mask_m, lines, en, gie)});
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule